// File: doc/BRIEF.md
# Long-Press Dual-Button Reset Timer

This block produces a system reset pulse only after two active-low push buttons have been held down together for a long, strap-selected interval. A brief or one-handed press never resets the device. If either button is released before the interval ends, the count is silently discarded. When the interval completes, the block drives a pulse of fixed length on a pair of complementary reset outputs, an active-low one and an active-high one.

Both button inputs pass through synchronizers. A prescaler divides the free-running clock into quarter-second-multiple units of 0.75 s. A unit counter compares the elapsed units with a target that is decoded from two straps. The straps are captured once after power-on reset. After a pulse the timer stays disarmed until at least one button has been let go, so a button pair that is held down indefinitely yields a single reset. The clock frequency is a parameter, so benches can run with scaled-down times. With a smaller frequency, every interval shrinks in proportion.

Top module: `lpr_reset_timer`

## Requirements
- R1: Only one button held low, with the other high, never starts the timer, and the outputs stay idle however long the press lasts.
- R2: A high sample on either button before the hold time completes clears the accumulated count. A later press must again last the full hold time, and the outputs do not change meanwhile.
- R3: The hold time is T units of UNIT_CYC = CLK_HZ*750/1000 clocks, with T taken from the captured straps {sel0,sel1}: 00 gives 4, 01 gives 5, 10 gives 6 and 11 gives 8. The outputs assert on the clock edge two cycles after the last of T*UNIT_CYC consecutive rising edges at which both raw buttons were sampled low.
- R4: With DUAL_SELECT=0, sel1 is ignored and treated as 0: sel0 low gives 4 units and sel0 high gives 6 units.
- R5: The active-low output is always the complement of the active-high output.
- R6: Each pulse lasts exactly PULSE_CYC = CLK_HZ*400/1000 clocks, after which the outputs return to idle (rst_o low, rst_n_o high).
- R7: The straps are sampled on the first clock edge after por_n_i is released. Later changes on the straps have no effect until the next reset.
- R8: After a pulse the timer re-arms only once a button has been seen high. Holding both buttons continuously produces exactly one pulse.
- R9: While por_n_i is low and right after it is released, the outputs are idle.
- R10: Button activity during a pulse does not shorten or extend the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running timing clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| btn_a_n_i | input | 1 | First button, active low, asynchronous |
| btn_b_n_i | input | 1 | Second button, active low, asynchronous |
| dly_sel0_i | input | 1 | Hold-time strap, bit 0 |
| dly_sel1_i | input | 1 | Hold-time strap, bit 1 (ignored in reduced variant) |
| rst_n_o | output | 1 | Reset pulse, active low |
| rst_o | output | 1 | Reset pulse, active high |

## Verification
A prescaler or unit counter that is off by one moves the pulse edge by one clock or by one whole unit. The latency measurements catch this on the first long press of each strap setting. A count that is not cleared on release shows up as an early pulse in the next press that falls just short of the hold time. A missing disarm shows up as a second pulse roughly one hold time after the first while the buttons stay down. A strap register that is not frozen gives a wrong latency on the first press after the straps are moved. The reference model compares both outputs on every clock, so any of these faults is reported in the cycle where the outputs first diverge.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

   typedef enum logic [1:0] {
      ST_ARMED = 2'd0,
      ST_PULSE = 2'd1,
      ST_WAIT  = 2'd2
   } lpr_state_e;

   localparam int unsigned MAX_UNITS = 8;
   localparam int unsigned UNIT_W    = $clog2(MAX_UNITS + 1);

   // strap pair {sel0,sel1} to hold time in 0.75 s units
   function automatic logic [UNIT_W-1:0] hold_units(input logic s0, input logic s1);
      logic [UNIT_W-1:0] u;
      case ({s0, s1})
         2'b00:   u = UNIT_W'(4);
         2'b01:   u = UNIT_W'(5);
         2'b10:   u = UNIT_W'(6);
         default: u = UNIT_W'(8);
      endcase
      return u;
   endfunction

endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
   parameter int unsigned STAGES   = 2,
   parameter logic        IDLE_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lpr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) sh_q <= {STAGES{IDLE_VAL}};
      else          sh_q <= {sh_q[STAGES-2:0], d_i};
   end

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/lpr_prescaler.sv
module lpr_prescaler #(
   parameter int unsigned UNIT_CYC = 24576
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic en_i,
   output logic tick_o
);
   localparam int unsigned CW = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(UNIT_CYC - 1);

   if (UNIT_CYC < 2) begin : g_bad_unit
      $error("lpr_prescaler: UNIT_CYC must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)          cnt_q <= '0;
      else if (!en_i)        cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/lpr_strap_latch.sv
module lpr_strap_latch
   import lpr_pkg::*;
#(
   parameter bit DUAL_SELECT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              sel0_i,
   input  logic              sel1_i,
   output logic [UNIT_W-1:0] units_o
);
   logic sel1_eff;
   logic sel0_q, sel1_q, taken_q;

   if (DUAL_SELECT) begin : g_dual
      assign sel1_eff = sel1_i;
   end else begin : g_single
      assign sel1_eff = 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         sel0_q  <= 1'b0;
         sel1_q  <= 1'b0;
         taken_q <= 1'b0;
      end else if (!taken_q) begin
         sel0_q  <= sel0_i;
         sel1_q  <= sel1_eff;
         taken_q <= 1'b1;
      end
   end

   assign units_o = hold_units(sel0_q, sel1_q);
endmodule

// File: rtl/lpr_hold_ctrl.sv
module lpr_hold_ctrl
   import lpr_pkg::*;
#(
   parameter int unsigned PULSE_CYC = 13107
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              both_low_i,
   input  logic              tick_i,
   input  logic [UNIT_W-1:0] target_i,
   output logic              count_en_o,
   output logic              pulse_o
);
   localparam int unsigned PW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
   localparam logic [PW-1:0] P_LAST = PW'(PULSE_CYC - 1);

   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("lpr_hold_ctrl: PULSE_CYC must be at least 1");
   end

   lpr_state_e        st_q;
   logic [UNIT_W-1:0] units_q;
   logic [PW-1:0]     pcnt_q;

   assign count_en_o = (st_q == ST_ARMED) && both_low_i;
   assign pulse_o    = (st_q == ST_PULSE);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         st_q    <= ST_ARMED;
         units_q <= '0;
         pcnt_q  <= '0;
      end else begin
         case (st_q)
            ST_ARMED: begin
               if (!both_low_i) begin
                  units_q <= '0;
               end else if (tick_i) begin
                  if (units_q == target_i - 1'b1) begin
                     st_q    <= ST_PULSE;
                     units_q <= '0;
                     pcnt_q  <= '0;
                  end else begin
                     units_q <= units_q + 1'b1;
                  end
               end
            end
            ST_PULSE: begin
               if (pcnt_q == P_LAST) st_q <= ST_WAIT;
               else                  pcnt_q <= pcnt_q + 1'b1;
            end
            default: begin
               if (!both_low_i) st_q <= ST_ARMED;
            end
         endcase
      end
   end
endmodule

// File: rtl/lpr_reset_timer.sv
module lpr_reset_timer
   import lpr_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 32768,
   parameter int unsigned UNIT_MS     = 750,
   parameter int unsigned PULSE_MS    = 400,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TOTAL_BITS  = 21,
   parameter bit          DUAL_SELECT = 1'b1
) (
   input  logic clk_i,
   input  logic por_n_i,
   input  logic btn_a_n_i,
   input  logic btn_b_n_i,
   input  logic dly_sel0_i,
   input  logic dly_sel1_i,
   output logic rst_n_o,
   output logic rst_o
);
   localparam int unsigned UNIT_CYC  = CLK_HZ * UNIT_MS / 1000;
   localparam int unsigned PULSE_CYC = CLK_HZ * PULSE_MS / 1000;
   localparam int unsigned PRE_W     = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;

   if (PRE_W + UNIT_W > TOTAL_BITS) begin : g_bad_width
      $error("lpr_reset_timer: prescaler plus unit counter exceed TOTAL_BITS");
   end

   logic [1:0]        btn_raw;
   logic [1:0]        btn_s;
   logic              both_low;
   logic              count_en;
   logic              tick;
   logic              pulse;
   logic [UNIT_W-1:0] target;

   assign btn_raw = {btn_b_n_i, btn_a_n_i};

   for (genvar g = 0; g < 2; g++) begin : g_sync
      lpr_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) sync_i (
         .clk_i   (clk_i),
         .rst_n_i (por_n_i),
         .d_i     (btn_raw[g]),
         .q_o     (btn_s[g])
      );
   end

   assign both_low = ~|btn_s;

   lpr_strap_latch #(.DUAL_SELECT(DUAL_SELECT)) straps_i (
      .clk_i   (clk_i),
      .rst_n_i (por_n_i),
      .sel0_i  (dly_sel0_i),
      .sel1_i  (dly_sel1_i),
      .units_o (target)
   );

   lpr_prescaler #(.UNIT_CYC(UNIT_CYC)) pre_i (
      .clk_i   (clk_i),
      .rst_n_i (por_n_i),
      .en_i    (count_en),
      .tick_o  (tick)
   );

   lpr_hold_ctrl #(.PULSE_CYC(PULSE_CYC)) ctrl_i (
      .clk_i      (clk_i),
      .rst_n_i    (por_n_i),
      .both_low_i (both_low),
      .tick_i     (tick),
      .target_i   (target),
      .count_en_o (count_en),
      .pulse_o    (pulse)
   );

   assign rst_o   = pulse;
   assign rst_n_o = ~pulse;
endmodule

// File: rtl/lpr_reset_timer_chk.sv
module lpr_reset_timer_chk #(
   parameter int unsigned UNIT_CYC  = 24576,
   parameter int unsigned PULSE_CYC = 13107
) (
   input logic clk_i,
   input logic por_n_i,
   input logic btn_a_n_i,
   input logic btn_b_n_i,
   input logic rst_n_o,
   input logic rst_o
);
   localparam logic [31:0] MIN_RUN = 32'(4 * UNIT_CYC);

   logic [31:0] low_run_q;
   logic [31:0] plen_q;
   logic        seen_rel_q;
   logic        rst_prev_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         low_run_q  <= '0;
         plen_q     <= '0;
         seen_rel_q <= 1'b1;
         rst_prev_q <= 1'b0;
      end else begin
         if (!btn_a_n_i && !btn_b_n_i) begin
            if (low_run_q != 32'hFFFF_FFFF) low_run_q <= low_run_q + 1'b1;
         end else begin
            low_run_q <= '0;
         end
         plen_q     <= rst_o ? plen_q + 1'b1 : '0;
         rst_prev_q <= rst_o;
         if (rst_o && !rst_prev_q)         seen_rel_q <= 1'b0;
         else if (btn_a_n_i || btn_b_n_i)  seen_rel_q <= 1'b1;
      end
   end

   // R5
   outs_complement_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
      rst_n_o == !rst_o);

   // R1
   both_low_before_fire_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $rose(rst_o) |-> $past(!btn_a_n_i && !btn_b_n_i, 3));

   // R3
   min_hold_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $rose(rst_o) |-> ($past(low_run_q, 2) >= MIN_RUN));

   // R6
   pulse_not_long_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
      rst_o |-> (plen_q < 32'(PULSE_CYC)));

   // R6
   pulse_full_len_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
      $fell(rst_o) |-> (plen_q == 32'(PULSE_CYC)));

   // R8
   rearm_after_release_chk: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (rst_o && !rst_prev_q) |-> seen_rel_q);
endmodule

bind lpr_reset_timer lpr_reset_timer_chk #(
   .UNIT_CYC  (UNIT_CYC),
   .PULSE_CYC (PULSE_CYC)
) chk_i (
   .clk_i     (clk_i),
   .por_n_i   (por_n_i),
   .btn_a_n_i (btn_a_n_i),
   .btn_b_n_i (btn_b_n_i),
   .rst_n_o   (rst_n_o),
   .rst_o     (rst_o)
);

// File: tb/lpr_reset_timer_tb.sv
`timescale 1ns/1ps
module lpr_reset_timer_tb_top;
   localparam int CLK_HZ = 40;
   localparam int U      = CLK_HZ * 750 / 1000;   // 30 clocks per unit
   localparam int P      = CLK_HZ * 400 / 1000;   // 16 clocks of pulse

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic a_n = 1'b1, b_n = 1'b1;
   logic s0 = 1'b0, s1 = 1'b0;
   logic rst_n_o, rst_o, r_rst_n_o, r_rst_o;

   int checks = 0;
   int errors = 0;
   int rises  = 0;
   logic prev_rst = 1'b0;

   always #2.5 clk = ~clk;

   lpr_reset_timer #(.CLK_HZ(CLK_HZ), .DUAL_SELECT(1'b1)) dut_i (
      .clk_i(clk), .por_n_i(por_n), .btn_a_n_i(a_n), .btn_b_n_i(b_n),
      .dly_sel0_i(s0), .dly_sel1_i(s1), .rst_n_o(rst_n_o), .rst_o(rst_o));

   lpr_reset_timer #(.CLK_HZ(CLK_HZ), .DUAL_SELECT(1'b0)) dut_r_i (
      .clk_i(clk), .por_n_i(por_n), .btn_a_n_i(a_n), .btn_b_n_i(b_n),
      .dly_sel0_i(s0), .dly_sel1_i(1'b1), .rst_n_o(r_rst_n_o), .rst_o(r_rst_o));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int   m_state;   // 0 armed, 1 pulse, 2 wait
   int   m_held, m_pcnt, m_units;
   bit   m_cap;
   bit   m_out;
   bit   lowq[$];

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_state = 0; m_held = 0; m_pcnt = 0; m_units = 4; m_cap = 0; m_out = 0;
         lowq = '{1'b0, 1'b0};
      end else begin
         bit lowd;
         lowd = lowq.pop_front();
         lowq.push_back(!a_n && !b_n);
         if (!m_cap) begin
            m_units = (s0 && s1) ? 8 : s0 ? 6 : s1 ? 5 : 4;
            m_cap = 1;
         end
         case (m_state)
            0: if (lowd) begin
                  m_held++;
                  if (m_held == m_units * U) begin m_state = 1; m_pcnt = 0; m_held = 0; end
               end else m_held = 0;
            1: begin m_pcnt++; if (m_pcnt == P) m_state = 2; end
            default: if (!lowd) m_state = 0;
         endcase
         m_out = (m_state == 1);
      end
   end

   always @(negedge clk) begin
      string tag;
      tag = (m_state == 0) ? "R3" : (m_state == 1) ? "R6" : "R8";
      chk(rst_o == m_out, tag, rst_o, m_out);
      chk(rst_n_o == !rst_o, "R5", rst_n_o, !rst_o);
      chk(r_rst_n_o == !r_rst_o, "R5", r_rst_n_o, !r_rst_o);
      if (rst_o && !prev_rst) rises++;
      prev_rst = rst_o;
   end

   task automatic do_reset(input logic v0, input logic v1);
      @(negedge clk);
      a_n = 1'b1; b_n = 1'b1; s0 = v0; s1 = v1; por_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(rst_o == 1'b0 && rst_n_o == 1'b1, "R9", rst_o, 0);
      por_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(rst_o == 1'b0 && rst_n_o == 1'b1, "R9", rst_o, 0);
   endtask

   task automatic idle(input int n);
      a_n = 1'b1; b_n = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   // press both and count negedges until each DUT fires
   task automatic measure(output int lat, output int lat_r);
      int n = 0;
      lat = -1; lat_r = -1;
      a_n = 1'b0; b_n = 1'b0;
      while ((lat < 0 || lat_r < 0) && n < 400) begin
         @(negedge clk); n++;
         if (lat < 0 && rst_o) lat = n;
         if (lat_r < 0 && r_rst_o) lat_r = n;
      end
   endtask

   initial begin
      int lat, lat_r, w, r0;
      do_reset(1'b0, 1'b0);

      // R1 one button at a time
      r0 = rises;
      a_n = 1'b0; repeat (300) @(negedge clk); a_n = 1'b1;
      b_n = 1'b0; repeat (300) @(negedge clk); b_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(rises == r0, "R1", rises, r0);
      chk(rst_o == 1'b0, "R1", rst_o, 0);

      // R3 latency 00, R6 width, R8 one pulse while held
      measure(lat, lat_r);
      chk(lat == 4 * U + 2, "R3", lat, 4 * U + 2);
      chk(lat_r == 4 * U + 2, "R4", lat_r, 4 * U + 2);
      w = 1;
      while (rst_o && w < 100) begin @(negedge clk); if (rst_o) w++; end
      chk(w == P, "R6", w, P);
      r0 = rises;
      repeat (3 * 8 * U) @(negedge clk);
      chk(rises == r0, "R8", rises, r0);
      chk(rst_o == 1'b0 && rst_n_o == 1'b1, "R8", rst_o, 0);
      // short release re-arms
      a_n = 1'b1; @(negedge clk);
      measure(lat, lat_r);
      chk(lat == 4 * U + 2, "R8", lat, 4 * U + 2);
      repeat (P + 2) @(negedge clk);
      idle(10);

      // R2 release one sample short, then retry short again
      r0 = rises;
      a_n = 1'b0; b_n = 1'b0; repeat (4 * U - 1) @(negedge clk);
      b_n = 1'b1; @(negedge clk);
      b_n = 1'b0; repeat (4 * U - 1) @(negedge clk);
      idle(10);
      chk(rises == r0, "R2", rises, r0);
      chk(rst_o == 1'b0, "R2", rst_o, 0);
      measure(lat, lat_r);
      chk(lat == 4 * U + 2, "R2", lat, 4 * U + 2);
      // R10 release right at pulse start
      idle(0);
      w = 1;
      while (rst_o && w < 100) begin @(negedge clk); if (rst_o) w++; end
      chk(w == P, "R10", w, P);
      idle(10);

      // R3 and R4 other strap settings
      do_reset(1'b0, 1'b1);
      measure(lat, lat_r);
      chk(lat == 5 * U + 2, "R3", lat, 5 * U + 2);
      chk(lat_r == 4 * U + 2, "R4", lat_r, 4 * U + 2);
      idle(P + 10);
      do_reset(1'b1, 1'b0);
      measure(lat, lat_r);
      chk(lat == 6 * U + 2, "R3", lat, 6 * U + 2);
      chk(lat_r == 6 * U + 2, "R4", lat_r, 6 * U + 2);
      idle(P + 10);
      do_reset(1'b1, 1'b1);
      measure(lat, lat_r);
      chk(lat == 8 * U + 2, "R3", lat, 8 * U + 2);
      chk(lat_r == 6 * U + 2, "R4", lat_r, 6 * U + 2);
      idle(P + 10);

      // R7 strap change after reset is ignored
      do_reset(1'b0, 1'b0);
      s0 = 1'b1; s1 = 1'b1;
      repeat (4) @(negedge clk);
      measure(lat, lat_r);
      chk(lat == 4 * U + 2, "R7", lat, 4 * U + 2);
      chk(lat_r == 4 * U + 2, "R7", lat_r, 4 * U + 2);
      idle(P + 10);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule